// File: doc/BRIEF.md
# Ratiometric Dual-Counter Measurement Sequencer

This block runs one conversion of a readout that measures the frequency ratio of two oscillators. A start request begins the conversion with a timed pre-charge phase. During this phase a capacitor-preset output and a reference enable are held high. When the phase ends, the preset is released and the oscillators are enabled. Two counters then count the rising edges of a reference oscillator input and a sensing oscillator input. Each input is first synchronized into the system clock domain.

A mode input is sampled when a conversion starts. It decides which counter sets the measurement window. In temperature mode the reference counter sets the window. In humidity mode the sensing counter sets it. When the window counter wraps past its maximum value, the other counter's value is loaded into a shift register. The enables drop and a data-ready flag rises. An external serial clock then shifts the result out, most significant bit first.

The oscillators are modelled as digital inputs. Each must run below half the system clock frequency.

Top module: `ratio_meas_seq`

## Requirements
- R1: A start request accepted while idle drives `preset_o` and `ref_en_o` high, while `osc_en_o` stays low.
- R2: `preset_o` stays high for exactly PRE_CYC system clock cycles, where PRE_CYC = (CLK_FREQ_HZ / 10^6) * PRECHARGE_NS / 1000. This is 4000 cycles at the defaults. In the cycle `preset_o` falls, `osc_en_o` rises.
- R3: Each of the two CNT_W-bit counters (16 bits by default) counts the rising edges of its own oscillator input after a two-flop synchronizer. It counts only while `osc_en_o` is high.
- R4: With `mode_i`=0 (temperature), the window ends at the 2^CNT_W-th reference edge. The captured value is the number of sensing edges seen before that edge.
- R5: With `mode_i`=1 (humidity), the window ends at the 2^CNT_W-th sensing edge. The captured value is the number of reference edges seen before that edge.
- R6: A measured-counter edge that arrives in the same cycle as the window-ending edge is not included. The measured counter wraps modulo 2^CNT_W, and that wrap does not end the window.
- R7: At capture, `data_ready_o` rises in the same cycle that `osc_en_o` and `ref_en_o` fall.
- R8: While `data_ready_o` is high, `sdata_o` presents the current result bit, starting with the MSB. Each synchronized rising edge of `sclk_i` advances it to the next lower bit.
- R9: `data_ready_o` falls after CNT_W serial clock rising edges, or when a new start is accepted.
- R10: A start request during pre-charge or counting is ignored.
- R11: `mode_i` is sampled at an accepted start. Changes to it during a conversion have no effect on that conversion.
- R12: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion start request |
| mode_i | input | 1 | 0 = temperature (reference window), 1 = humidity (sensing window) |
| ref_osc_i | input | 1 | Reference oscillator output, asynchronous |
| sns_osc_i | input | 1 | Sensing oscillator output, asynchronous |
| sclk_i | input | 1 | External serial shift clock, asynchronous |
| ref_en_o | output | 1 | Reference (bias) enable |
| preset_o | output | 1 | Capacitor preset during pre-charge |
| osc_en_o | output | 1 | Enable for both oscillators |
| data_ready_o | output | 1 | Result available for shifting |
| sdata_o | output | 1 | Serial result bit, MSB first |

## Verification
The bench drives oscillator pairs with different period ratios in both modes. A faster measured oscillator against a slower window oscillator in temperature mode shows that the roles follow the mode. Swapping to humidity mode shows that the window moves to the sensing input. Equal periods produce edges in the same cycle, which shows the exclusion rule of R6. A measured oscillator twice as fast as the window oscillator makes the measured counter wrap, which shows that the wrap does not end the window. Further runs apply a start and a mode flip mid-count, and a restart while a result is half shifted out. Together these separate the busy-ignore, mode-latch and ready-clear behaviour.

// File: rtl/ratio_seq_pkg.sv
package ratio_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_COUNT} seq_state_e;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/sync_rise.sv
module sync_rise #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // sh[STAGES-1:0] synchronizer, sh[STAGES] previous synced value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/edge_counter.sv
module edge_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] value_o,
  output logic         wrap_o
);
  logic [W-1:0] value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    value_q <= '0;
    else if (clr_i) value_q <= '0;
    else if (inc_i) value_q <= value_q + 1'b1;
  end

  assign value_o = value_q;
  assign wrap_o  = inc_i & (&value_q);

  // R3
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (value_o == '0));
  // R3
  inc_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (value_o != $past(value_o)));
endmodule

// File: rtl/piso_shift.sv
module piso_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  input  logic         shift_i,
  output logic         sdata_o,
  output logic         ready_o
);
  localparam int unsigned BW = $clog2(W + 1);

  logic [W-1:0]  sr_q;
  logic [BW-1:0] left_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      left_q  <= '0;
      ready_q <= 1'b0;
    end else if (load_i) begin
      sr_q    <= load_val_i;
      left_q  <= BW'(W);
      ready_q <= 1'b1;
    end else if (clr_i) begin
      left_q  <= '0;
      ready_q <= 1'b0;
    end else if (shift_i && ready_q) begin
      sr_q   <= {sr_q[W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
      if (left_q == BW'(1)) ready_q <= 1'b0;
    end
  end

  assign sdata_o = ready_q & sr_q[W-1];
  assign ready_o = ready_q;

  // R7
  ready_from_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(load_i));
  // R9
  ready_drop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> ($past(clr_i) || $past(shift_i)));
endmodule

// File: rtl/ratio_meas_seq.sv
module ratio_meas_seq
  import ratio_seq_pkg::*;
#(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned CLK_FREQ_HZ  = 200_000_000,
  parameter int unsigned PRECHARGE_NS = 20_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_i,
  input  logic ref_osc_i,
  input  logic sns_osc_i,
  input  logic sclk_i,
  output logic ref_en_o,
  output logic preset_o,
  output logic osc_en_o,
  output logic data_ready_o,
  output logic sdata_o
);
  localparam int unsigned PRE_CYC = (CLK_FREQ_HZ / 1_000_000) * PRECHARGE_NS / 1000;
  localparam int unsigned TW      = $clog2(PRE_CYC + 1);

  seq_state_e state_q;
  logic       mode_q;
  logic [TW-1:0] pre_q;

  logic [1:0]            osc_raw, osc_rise, cnt_wrap;
  logic [1:0][CNT_W-1:0] cnt_val;
  logic counting, cnt_clr, start_ok, win_wrap, capture, sclk_rise;
  logic [CNT_W-1:0] cap_val;

  assign counting = (state_q == ST_COUNT);
  assign cnt_clr  = ~counting;
  assign start_ok = start_i && (state_q == ST_IDLE);
  assign osc_raw  = {sns_osc_i, ref_osc_i};

  // channel 0: reference oscillator, channel 1: sensing oscillator
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (osc_raw[ch]),
      .rise_o  (osc_rise[ch])
    );
    edge_counter #(.W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (cnt_clr),
      .inc_i   (osc_rise[ch] & counting),
      .value_o (cnt_val[ch]),
      .wrap_o  (cnt_wrap[ch])
    );
  end

  // mode 0: reference sets window; mode 1: sensing sets window
  assign win_wrap = mode_q ? cnt_wrap[1] : cnt_wrap[0];
  assign cap_val  = mode_q ? cnt_val[0]  : cnt_val[1];
  assign capture  = counting && win_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      pre_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q <= ST_PRE;
          mode_q  <= mode_i;
          pre_q   <= '0;
        end
        ST_PRE: begin
          if (pre_q == TW'(PRE_CYC - 1)) state_q <= ST_COUNT;
          else                           pre_q   <= pre_q + 1'b1;
        end
        ST_COUNT: if (capture) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign preset_o = (state_q == ST_PRE);
  assign osc_en_o = counting;
  assign ref_en_o = (state_q != ST_IDLE);

  sync_rise #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sclk_i),
    .rise_o  (sclk_rise)
  );

  piso_shift #(.W(CNT_W)) u_piso (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (capture),
    .load_val_i (cap_val),
    .clr_i      (start_ok),
    .shift_i    (sclk_rise),
    .sdata_o    (sdata_o),
    .ready_o    (data_ready_o)
  );

  // R1
  preset_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(preset_o) |-> ($past(start_i) && !osc_en_o && ref_en_o));
  // R2
  preset_handoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(preset_o) |-> (osc_en_o && $past(pre_q) == TW'(PRE_CYC - 1)));
  // R7
  capture_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> (data_ready_o && !ref_en_o));
  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_o && start_i) |=> !preset_o);
  // R11
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(mode_q));
endmodule

// File: tb/tb_ratio_meas_seq.sv
`timescale 1ns/100ps
module tb_ratio_meas_seq;
  localparam int W       = 8;
  localparam int WIN     = 1 << W;
  localparam int PRE_NS  = 200;
  localparam int PRE_CYC = 200 * PRE_NS / 1000;

  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic ref_osc = 0, sns_osc = 0, sclk = 0;
  logic ref_en, preset, osc_en, ready, sdata;

  int checks = 0, fails = 0;
  int hr = 2, hs = 2;
  bit bmode = 0;
  int pr = 0, ps = 0, er = 0, es = 0;
  bit armed = 1;
  bit done = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  ratio_meas_seq #(.CNT_W(W), .CLK_FREQ_HZ(200_000_000), .PRECHARGE_NS(PRE_NS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .ref_osc_i(ref_osc), .sns_osc_i(sns_osc), .sclk_i(sclk),
    .ref_en_o(ref_en), .preset_o(preset), .osc_en_o(osc_en),
    .data_ready_o(ready), .sdata_o(sdata)
  );

  // oscillator model and scoreboard driver: pushes expected captured count
  always @(negedge clk) begin
    bit rr, rs;
    rr = 0; rs = 0;
    if (!osc_en) begin
      pr = 0; ps = 0; ref_osc = 0; sns_osc = 0; er = 0; es = 0; armed = 1;
    end else begin
      pr++;
      if (pr == hr) begin pr = 0; ref_osc = ~ref_osc; rr = ref_osc; end
      ps++;
      if (ps == hs) begin ps = 0; sns_osc = ~sns_osc; rs = sns_osc; end
      if (armed) begin
        if (!bmode && rr && er + 1 == WIN) begin exp_q.push_back(es % WIN); armed = 0; end
        else if (bmode && rs && es + 1 == WIN) begin exp_q.push_back(er % WIN); armed = 0; end
        if (rr) er++;
        if (rs) es++;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sclk_pulse();
    sclk = 1; repeat (3) @(negedge clk);
    sclk = 0; repeat (3) @(negedge clk);
  endtask

  task automatic do_start(bit m, int r_half, int s_half);
    int n;
    @(negedge clk);
    hr = r_half; hs = s_half;
    mode = m; bmode = m; start = 1;
    @(negedge clk);
    start = 0;
    chk("R1 preset", preset, 1);
    chk("R1 ref_en", ref_en, 1);
    chk("R1 osc_en", osc_en, 0);
    chk("R9 ready cleared by start", ready, 0);
    n = 1;
    while (n < PRE_CYC + 10) begin
      @(negedge clk);
      if (preset) n++; else break;
    end
    chk("R2 preset length", n, PRE_CYC);
    chk("R2 osc_en after preset", osc_en, 1);
  endtask

  task automatic read_result(string req);
    int v, e;
    while (!ready) @(negedge clk);
    chk("R7 osc_en low at capture", osc_en, 0);
    chk("R7 ref_en low at capture", ref_en, 0);
    v = 0;
    for (int i = 0; i < W; i++) begin
      v = (v << 1) | int'(sdata);
      sclk_pulse();
    end
    chk("R9 ready low after shift", ready, 0);
    if (exp_q.size() == 0) begin
      e = -1;
    end else begin
      e = exp_q.pop_front();
    end
    chk(req, v, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12
    chk("R12 ref_en", ref_en, 0);
    chk("R12 preset", preset, 0);
    chk("R12 osc_en", osc_en, 0);
    chk("R12 ready", ready, 0);
    chk("R12 sdata", sdata, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 temperature: sensing faster than reference
    do_start(0, 3, 2);
    read_result("R4 R3 temperature capture");

    // R5 humidity: window on sensing, reference slower
    do_start(1, 4, 2);
    read_result("R5 humidity capture");

    // R6 equal periods: simultaneous final edge excluded
    do_start(0, 2, 2);
    read_result("R6 simultaneous edge");
    chk("R6 simultaneous expected 255", WIN - 1, 255);

    // R6 measured counter wraps without ending window
    do_start(0, 4, 2);
    read_result("R6 measured wrap");

    // R10 R11 busy start and mode flip mid-count
    do_start(1, 3, 2);
    repeat (100) @(negedge clk);
    start = 1; mode = 0;
    @(negedge clk);
    start = 0;
    begin
      int hi;
      hi = 0;
      repeat (4) begin
        @(negedge clk);
        if (preset || !osc_en) hi++;
      end
      chk("R10 busy start ignored", hi, 0);
    end
    read_result("R11 mode held humidity result");

    // R8 MSB first on partial shift, then R9 restart clears ready
    do_start(0, 2, 3);
    while (!ready) @(negedge clk);
    begin
      int e, b;
      e = (exp_q.size() != 0) ? exp_q[0] : 0;
      for (int i = 0; i < 3; i++) begin
        b = int'(sdata);
        chk("R8 serial bit", b, (e >> (W - 1 - i)) & 1);
        sclk_pulse();
      end
      chk("R8 ready mid-shift", ready, 1);
      if (exp_q.size() != 0) void'(exp_q.pop_front());
    end
    do_start(1, 2, 2);
    read_result("R5 R9 result after restart");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule